// File: doc/BRIEF.md
# T1 Frame Payload Slot Mapper

This block sits behind a T1 line receiver. It takes the line's serial bit stream, one bit per clock at the 1.544 MHz line rate, together with a pulse that marks the framing bit of a frame. It follows the position of every bit inside the 193-bit frame. A frame is one framing bit followed by 24 time slots of 8 bits each, and each slot arrives most significant bit first. The block raises a flag for each bit that counts as payload. It packs every useful slot into an octet and hands that octet out with the slot number.

A mode input chooses between two views of the frame. In normal operation all 24 slots are payload. In ISDN operation only slots 1 to 23 are payload, and slot 24 is dropped in the same way as the framing bit. The framing bit is never payload in either view. The mode is sampled at each framing bit, so a change made during a frame first applies to the following frame.

The position tracker is a four-state machine:
- HUNT is the state after reset. Bits are ignored until the first frame pulse arrives.
- FRAME is the state for the framing bit.
- DATA is the state for a payload slot.
- SKIP is the state for slot 24 in ISDN operation.

Its transitions are as follows:
- A frame pulse forces FRAME from any state.
- FRAME always moves to DATA at slot 1, bit 0.
- DATA moves to the next slot after its eighth bit.
- After slot 23 in ISDN operation, DATA moves to SKIP.
- After slot 24, DATA moves to FRAME.
- SKIP moves to FRAME after its eighth bit.

Without a new pulse, the machine keeps counting frames on its own. This is the flywheel.

Top module: `t1_slot_mapper`

## Requirements
- R1: After reset `octet_valid` and `payload_flag` are 0. Until the first `frame_sync` pulse, no bit is treated as payload and no octet is produced. Reset asserted at any time returns the block to this state.
- R2: The bit presented with `frame_sync` high is the framing bit. `payload_flag` is 0 for it, and it never enters an octet.
- R3: With `isdn_mode` = 0 latched, every frame produces exactly 24 octets for slots 1 to 24. `payload_flag` is 1 for all 192 slot bits.
- R4: With `isdn_mode` = 1 latched, a frame produces exactly 23 octets for slots 1 to 23. `payload_flag` is 0 for the 8 bits of slot 24, and no octet is produced with slot number 24.
- R5: The first bit of a slot becomes bit 7 of `octet_data` and the eighth bit becomes bit 0. The octet appears on the clock edge after the slot's eighth bit is sampled.
- R6: `octet_valid` is high for exactly one cycle per octet and is never high on two consecutive cycles.
- R7: If no pulse arrives, the bit after the end of slot 24 is taken as the next framing bit. The bits after it are counted as a new frame starting at slot 1.
- R8: A `frame_sync` pulse in the middle of a frame restarts counting at the framing bit. The partly received octet is dropped, and the next octet produced is slot 1.
- R9: `isdn_mode` is sampled only at a framing bit. A change during a frame does not alter that frame's payload pattern or its octet count.
- R10: `octet_slot` is a 5-bit slot number counting from 1. On every valid octet it lies between 1 and 24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line bit clock, one bit per rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_bit | input | 1 | Serial line data |
| frame_sync | input | 1 | High on the framing bit of a frame |
| isdn_mode | input | 1 | 1 selects 23 payload slots, 0 selects 24 |
| payload_flag | output | 1 | The current input bit is payload (combinational) |
| octet_valid | output | 1 | One-cycle strobe for a completed octet |
| octet_data | output | 8 | Completed octet, first received bit in bit 7 |
| octet_slot | output | 5 | Slot number of the octet, counting from 1 |

## Verification
The flywheel case is the hardest to reach from the ports. There, a frame boundary occurs with no pulse, and that boundary has to fall right after slot 24, or right after the dropped slot 24 in ISDN operation. The bench reaches it by finishing a frame with one extra pulse-free bit on the framing position. It then sends a whole frame with no pulse at all, which only decodes correctly if the machine wrapped by itself. The mid-frame mode change and the mid-frame resync are driven in the middle of slot bits, so that the latched mode and the dropped partial octet can be told apart from the live inputs.

// File: rtl/t1_map_pkg.sv
package t1_map_pkg;
    typedef enum logic [1:0] {
        ST_HUNT  = 2'd0,
        ST_FRAME = 2'd1,
        ST_DATA  = 2'd2,
        ST_SKIP  = 2'd3
    } pos_state_t;
endpackage

// File: rtl/t1_pos_fsm.sv
module t1_pos_fsm
    import t1_map_pkg::*;
#(
    parameter int SLOTS   = 24,
    parameter int OCTET_W = 8,
    localparam int SLOT_W = $clog2(SLOTS + 1),
    localparam int BIT_W  = $clog2(OCTET_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_sync,
    input  logic              isdn_mode,
    output logic              in_payload,
    output logic              octet_done,
    output logic [SLOT_W-1:0] slot_idx,
    output logic              frame_isdn
);
    localparam logic [BIT_W-1:0]  LAST_BIT  = BIT_W'(OCTET_W - 1);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS);
    localparam logic [SLOT_W-1:0] CUT_SLOT  = SLOT_W'(SLOTS - 1);

    pos_state_t        state_q, cur_state, nxt_state;
    logic [BIT_W-1:0]  bit_q;
    logic [SLOT_W-1:0] slot_q;
    logic              mode_q;
    logic              last_bit;

    always_comb cur_state = frame_sync ? ST_FRAME : state_q;
    assign last_bit = (bit_q == LAST_BIT);

    always_comb begin
        nxt_state = cur_state;
        unique case (cur_state)
            ST_HUNT:  nxt_state = ST_HUNT;
            ST_FRAME: nxt_state = ST_DATA;
            ST_DATA: begin
                if (last_bit) begin
                    if (slot_q == LAST_SLOT)
                        nxt_state = ST_FRAME;
                    else if (slot_q == CUT_SLOT && mode_q)
                        nxt_state = ST_SKIP;
                    else
                        nxt_state = ST_DATA;
                end
            end
            ST_SKIP:  nxt_state = last_bit ? ST_FRAME : ST_SKIP;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
            bit_q   <= '0;
            slot_q  <= '0;
            mode_q  <= 1'b0;
        end else begin
            state_q <= nxt_state;
            unique case (cur_state)
                ST_HUNT: begin
                    bit_q  <= '0;
                    slot_q <= '0;
                end
                ST_FRAME: begin
                    bit_q  <= '0;
                    slot_q <= SLOT_W'(1);
                    mode_q <= isdn_mode;
                end
                ST_DATA, ST_SKIP: begin
                    if (last_bit) begin
                        bit_q  <= '0;
                        slot_q <= slot_q + SLOT_W'(1);
                    end else begin
                        bit_q  <= bit_q + BIT_W'(1);
                    end
                end
            endcase
        end
    end

    always_comb begin
        in_payload = (cur_state == ST_DATA);
        octet_done = in_payload && last_bit;
        slot_idx   = slot_q;
        frame_isdn = mode_q;
    end
endmodule

// File: rtl/t1_octet_pack.sv
module t1_octet_pack #(
    parameter int OCTET_W = 8,
    parameter int SLOT_W  = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               shift_en,
    input  logic               done,
    input  logic               din,
    input  logic [SLOT_W-1:0]  slot_in,
    output logic               valid,
    output logic [OCTET_W-1:0] data,
    output logic [SLOT_W-1:0]  slot
);
    logic [OCTET_W-2:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q  <= '0;
            valid <= 1'b0;
            data  <= '0;
            slot  <= '0;
        end else begin
            valid <= done;
            if (shift_en)
                sh_q <= {sh_q[OCTET_W-3:0], din};
            if (done) begin
                data <= {sh_q, din};
                slot <= slot_in;
            end
        end
    end
endmodule

// File: rtl/t1_slot_mapper.sv
module t1_slot_mapper #(
    parameter int SLOTS   = 24,
    parameter int OCTET_W = 8,
    localparam int SLOT_W = $clog2(SLOTS + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               line_bit,
    input  logic               frame_sync,
    input  logic               isdn_mode,
    output logic               payload_flag,
    output logic               octet_valid,
    output logic [OCTET_W-1:0] octet_data,
    output logic [SLOT_W-1:0]  octet_slot
);
    logic              in_payload;
    logic              octet_done;
    logic [SLOT_W-1:0] slot_idx;
    logic              frame_isdn;

    t1_pos_fsm #(.SLOTS(SLOTS), .OCTET_W(OCTET_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_sync (frame_sync),
        .isdn_mode  (isdn_mode),
        .in_payload (in_payload),
        .octet_done (octet_done),
        .slot_idx   (slot_idx),
        .frame_isdn (frame_isdn)
    );

    t1_octet_pack #(.OCTET_W(OCTET_W), .SLOT_W(SLOT_W)) u_pack (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (in_payload),
        .done     (octet_done),
        .din      (line_bit),
        .slot_in  (slot_idx),
        .valid    (octet_valid),
        .data     (octet_data),
        .slot     (octet_slot)
    );

    assign payload_flag = in_payload;
endmodule

// File: rtl/t1_slot_mapper_chk.sv
module t1_slot_mapper_chk #(
    parameter int SLOT_W = 5,
    parameter int SLOTS  = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_sync,
    input logic              payload_flag,
    input logic              octet_valid,
    input logic [SLOT_W-1:0] octet_slot,
    input logic              frame_isdn
);
    p_reset_quiet_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> !octet_valid);

    p_fbit_not_payload_r2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_sync |-> !payload_flag);

    p_no_slot24_isdn_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (octet_valid && frame_isdn) |-> (octet_slot != SLOT_W'(SLOTS)));

    p_single_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        octet_valid |=> !octet_valid);

    p_slot_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        octet_valid |-> (octet_slot >= SLOT_W'(1) && octet_slot <= SLOT_W'(SLOTS)));
endmodule

bind t1_slot_mapper t1_slot_mapper_chk #(.SLOT_W(SLOT_W), .SLOTS(SLOTS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_sync   (frame_sync),
    .payload_flag (payload_flag),
    .octet_valid  (octet_valid),
    .octet_slot   (octet_slot),
    .frame_isdn   (frame_isdn)
);

// File: tb/t1_slot_mapper_bench.sv
module t1_slot_mapper_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_bit = 1'b0;
    logic       frame_sync = 1'b0;
    logic       isdn_mode = 1'b0;
    logic       payload_flag;
    logic       octet_valid;
    logic [7:0] octet_data;
    logic [4:0] octet_slot;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    logic [7:0] cap_data [64];
    logic [4:0] cap_slot [64];
    int  cap_n = 0;
    bit  prev_v = 0;

    always #5 clk = ~clk;

    t1_slot_mapper u_t1_slot_mapper (
        .clk(clk), .rst_n(rst_n), .line_bit(line_bit), .frame_sync(frame_sync),
        .isdn_mode(isdn_mode), .payload_flag(payload_flag), .octet_valid(octet_valid),
        .octet_data(octet_data), .octet_slot(octet_slot)
    );

    // {expected octet count, isdn mode, base pattern}
    localparam logic [13:0] VEC [6] = '{
        {5'd24, 1'b0, 8'h5A},
        {5'd23, 1'b1, 8'hC3},
        {5'd24, 1'b0, 8'h00},
        {5'd23, 1'b1, 8'hFF},
        {5'd23, 1'b1, 8'h96},
        {5'd24, 1'b0, 8'h3C}
    };

    function automatic logic [7:0] val(input logic [7:0] base, input int s);
        return base ^ 8'(s * 37);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // R6: strobe never on two consecutive cycles
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_v && octet_valid) begin
                checks++;
                failures++;
                $display("FAIL R6 actual=%0h expected=%0h", 1, 0);
            end
            if (octet_valid && cap_n < 64) begin
                cap_data[cap_n] = octet_data;
                cap_slot[cap_n] = octet_slot;
                cap_n++;
            end
        end
        prev_v = octet_valid;
    end

    task automatic send_frame(input bit mode, input logic [7:0] base, input bit sync,
                              input bit skip_fbit, input bit flip_mid);
        int pf_err = 0;
        if (!skip_fbit) begin
            @(negedge clk);
            isdn_mode = mode; frame_sync = sync; line_bit = 1'b1;
            #1 chk(payload_flag == 1'b0, "R2", payload_flag, 0);
        end
        for (int s = 1; s <= 24; s++) begin
            for (int b = 7; b >= 0; b--) begin
                logic [7:0] v;
                v = val(base, s);
                @(negedge clk);
                frame_sync = 1'b0;
                line_bit = v[b];
                if (flip_mid && s == 12 && b == 7) isdn_mode = ~mode;
                #1;
                if (payload_flag !== !(mode && s == 24)) pf_err++;
            end
        end
        chk(pf_err == 0, mode ? "R4 payload flag" : "R3 payload flag", pf_err, 0);
        // next framing position reached by the flywheel, no pulse (R7)
        @(negedge clk);
        frame_sync = 1'b0; line_bit = 1'b0;
        #1 chk(payload_flag == 1'b0, "R7 flywheel framing bit", payload_flag, 0);
        #1;
    endtask

    task automatic check_frame(input bit mode, input logic [7:0] base, input int off,
                               input string req);
        int exp_n = mode ? 23 : 24;
        int bad = 0;
        chk(cap_n == off + exp_n, req, cap_n, off + exp_n);
        for (int i = 0; i < exp_n && off + i < 64; i++) begin
            if (cap_data[off+i] !== val(base, i + 1) || cap_slot[off+i] !== 5'(i + 1)) bad++;
        end
        chk(bad == 0, "R5/R10 octet content and slot", bad, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; failures++;
            $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: reset state and hunting
        repeat (3) @(negedge clk);
        #1 chk(octet_valid == 0 && payload_flag == 0, "R1 reset outputs", octet_valid, 0);
        @(negedge clk); rst_n = 1'b1;
        cap_n = 0;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk); line_bit = 1'(i % 3);
            #1 if (payload_flag) chk(0, "R1 hunt payload", 1, 0);
        end
        #1 chk(cap_n == 0, "R1 no octet before pulse", cap_n, 0);

        // table of frames, R3 and R4
        for (int i = 0; i < 6; i++) begin
            cap_n = 0;
            send_frame(VEC[i][8], VEC[i][7:0], 1'b1, 1'b0, 1'b0);
            chk(cap_n == int'(VEC[i][13:9]), "R3/R4 octet count", cap_n, VEC[i][13:9]);
            check_frame(VEC[i][8], VEC[i][7:0], 0, "R3/R4 frame");
        end

        // R7: flywheel frame, no pulse at all (mode kept at 1 from last ISDN frame)
        cap_n = 0;
        send_frame(1'b1, 8'h41, 1'b1, 1'b0, 1'b0);
        cap_n = 0;
        send_frame(1'b1, 8'h77, 1'b0, 1'b1, 1'b0);
        check_frame(1'b1, 8'h77, 0, "R7 flywheel frame");

        // R9: mode flips in mid-frame, both directions
        cap_n = 0;
        send_frame(1'b1, 8'hA5, 1'b1, 1'b0, 1'b1);
        check_frame(1'b1, 8'hA5, 0, "R9 isdn frame keeps 23");
        cap_n = 0;
        send_frame(1'b0, 8'h5C, 1'b1, 1'b0, 1'b1);
        check_frame(1'b0, 8'h5C, 0, "R9 normal frame keeps 24");

        // R8: pulse in mid-frame after 37 slot bits
        cap_n = 0;
        @(negedge clk); isdn_mode = 1'b0; frame_sync = 1'b1; line_bit = 1'b0;
        for (int k = 0; k < 37; k++) begin
            logic [7:0] v;
            v = val(8'h11, k / 8 + 1);
            @(negedge clk); frame_sync = 1'b0; line_bit = v[7 - (k % 8)];
        end
        send_frame(1'b0, 8'h22, 1'b1, 1'b0, 1'b0);
        chk(cap_n == 28, "R8 total after resync", cap_n, 28);
        chk(cap_slot[3] == 5'd4 && cap_data[3] == val(8'h11, 4), "R8 last pre-resync octet",
            cap_slot[3], 4);
        check_frame(1'b0, 8'h22, 4, "R8 frame after resync");
        chk(cap_slot[4] == 5'd1, "R8 first slot after resync", cap_slot[4], 1);

        // R1: reset in mid-frame returns to hunting
        @(negedge clk); frame_sync = 1'b1;
        repeat (20) begin @(negedge clk); frame_sync = 1'b0; line_bit = ~line_bit; end
        rst_n = 1'b0;
        @(negedge clk);
        #1 chk(octet_valid == 0 && payload_flag == 0, "R1 reset mid-frame", octet_valid, 0);
        @(negedge clk); rst_n = 1'b1;
        cap_n = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk); line_bit = 1'b1;
            #1 if (payload_flag) chk(0, "R1 hunt after reset", 1, 0);
        end
        #1 chk(cap_n == 0, "R1 no octet after reset", cap_n, 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule